// File: doc/BRIEF.md
# Symmetric Segmented Thermometer Decoder

This block sits ahead of a segmented current-steering converter array whose output range is built from two complementary cell banks, one serving the lower half of the range and one the upper half. Each sample clock it takes a 12-bit code and produces registered thermometer control words together with the bank-routing switch enables. The decode and the register form one clocked stage, so every segment and every routing signal changes on the same edge.

The most significant code bit is not decoded. It chooses the half of the transfer curve and sets the fill direction of every segment. The remaining 11 bits form three fields: a coarse field of 3 bits (7 lines, weight 256), a middle field of 3 bits (7 lines, weight 32) and a fine field of 5 bits (31 lines, weight 1). With the half bit low, the number of lit lines in each segment rises with its field value. With the half bit high, it falls, so the line pattern mirrors about mid-scale. The same half bit decides which bank drives the true output and which drives the inverted output.

Top module: `sym_therm_dec`

## Requirements
- R1: While rst_ni is low, all thermometer lines are 0, upper_o is 0, p_to_true_o and n_to_inv_o are 1, and n_to_true_o and p_to_inv_o are 0. Reset takes effect without waiting for a clock edge.
- R2: Every output changes only on a rising clk_i edge and reflects the code sampled at that edge. All three segments and the routing signals update on the same edge.
- R3: The fields are taken as coarse = code_i[10:8], middle = code_i[7:5], fine = code_i[4:0]. The half bit is code_i[11].
- R4: With code_i[11] = 0, the number of 1s in each segment equals its field value.
- R5: With code_i[11] = 1, the number of 1s in each segment equals (2^w - 1) minus its field value, where w is the field width.
- R6: Each segment word is a thermometer code: its 1s occupy bit 0 upward with no gaps.
- R7: 256*ones(coarse_o) + 32*ones(mid_o) + ones(fine_o) equals code_i[10:0] when code_i[11] = 0, and 2047 - code_i[10:0] when code_i[11] = 1.
- R8: Codes c and 4095 - c give identical thermometer lines and opposite upper_o. Codes 2047 and 2048 both light every line.
- R9: upper_o equals code_i[11]. With upper_o = 0, p_to_true_o = 1 and n_to_inv_o = 1. With upper_o = 1, n_to_true_o = 1 and p_to_inv_o = 1. Each output has exactly one bank enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 12 | Sample code; bit 11 selects the half |
| coarse_o | output | 7 | Coarse segment thermometer lines |
| mid_o | output | 7 | Middle segment thermometer lines |
| fine_o | output | 31 | Fine segment thermometer lines |
| upper_o | output | 1 | Registered half select; 1 selects the upper bank |
| p_to_true_o | output | 1 | Lower-half bank drives the true output |
| n_to_true_o | output | 1 | Upper-half bank drives the true output |
| p_to_inv_o | output | 1 | Lower-half bank drives the inverted output |
| n_to_inv_o | output | 1 | Upper-half bank drives the inverted output |

## Verification
The hardest condition to reach is the mirrored pairing across the half boundary. A fault in one direction of one segment only shows up when the line set of a code is compared with that of its complement, and this includes the 2047/2048 seam, where both codes must light every line. The stimulus applies each lower-half code, captures its lines, then applies its complement on the next cycle and compares. A full sweep of all 4096 codes separately checks the per-segment counts, the thermometer form and the routing against values derived from the code. A reset pulled low in the middle of a cycle checks that reset acts without a clock edge.

// File: rtl/sym_therm_pkg.sv
package sym_therm_pkg;
  typedef struct packed {
    logic p_true;
    logic n_true;
    logic p_inv;
    logic n_inv;
  } route_t;

  localparam route_t ROUTE_LOWER = '{p_true: 1'b1, n_true: 1'b0, p_inv: 1'b0, n_inv: 1'b1};
  localparam route_t ROUTE_UPPER = '{p_true: 1'b0, n_true: 1'b1, p_inv: 1'b1, n_inv: 1'b0};
endpackage

// File: rtl/seg_split.sv
module seg_split #(
  parameter int COARSE_W = 3,
  parameter int MID_W    = 3,
  parameter int FINE_W   = 5,
  localparam int SEG_W   = COARSE_W + MID_W + FINE_W
) (
  input  logic [SEG_W-1:0]    low_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [MID_W-1:0]    mid_o,
  output logic [FINE_W-1:0]   fine_o
);
  assign coarse_o = low_i[SEG_W-1 -: COARSE_W];
  assign mid_o    = low_i[FINE_W +: MID_W];
  assign fine_o   = low_i[FINE_W-1:0];
endmodule

// File: rtl/sym_seg_dec.sv
module sym_seg_dec #(
  parameter int W = 3
) (
  input  logic [W-1:0]        val_i,
  input  logic                dir_i,
  output logic [(1<<W)-2:0]   therm_o
);
  // dir_i = 1 mirrors the field: count becomes (2^W-1) - val_i
  logic [W-1:0] eff;
  assign eff = val_i ^ {W{dir_i}};

  for (genvar k = 0; k < (1 << W) - 1; k++) begin : g_line
    assign therm_o[k] = ({1'b0, eff} > (W+1)'(k));
  end
endmodule

// File: rtl/bank_route.sv
module bank_route
  import sym_therm_pkg::*;
(
  input  logic   upper_i,
  output route_t route_o
);
  assign route_o = upper_i ? ROUTE_UPPER : ROUTE_LOWER;
endmodule

// File: rtl/sym_therm_dec.sv
module sym_therm_dec
  import sym_therm_pkg::*;
#(
  parameter int COARSE_W = 3,
  parameter int MID_W    = 3,
  parameter int FINE_W   = 5,
  localparam int SEG_W   = COARSE_W + MID_W + FINE_W,
  localparam int CODE_W  = SEG_W + 1,
  localparam int CL      = (1 << COARSE_W) - 1,
  localparam int ML      = (1 << MID_W) - 1,
  localparam int FL      = (1 << FINE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [CL-1:0]     coarse_o,
  output logic [ML-1:0]     mid_o,
  output logic [FL-1:0]     fine_o,
  output logic              upper_o,
  output logic              p_to_true_o,
  output logic              n_to_true_o,
  output logic              p_to_inv_o,
  output logic              n_to_inv_o
);
  localparam int SEG_MAX = (1 << SEG_W) - 1;

  logic                upper_d;
  logic [COARSE_W-1:0] coarse_f;
  logic [MID_W-1:0]    mid_f;
  logic [FINE_W-1:0]   fine_f;
  logic [CL-1:0]       coarse_d;
  logic [ML-1:0]       mid_d;
  logic [FL-1:0]       fine_d;
  route_t              route_d, route_q;

  assign upper_d = code_i[CODE_W-1];

  seg_split #(.COARSE_W(COARSE_W), .MID_W(MID_W), .FINE_W(FINE_W)) u_split (
    .low_i    (code_i[SEG_W-1:0]),
    .coarse_o (coarse_f),
    .mid_o    (mid_f),
    .fine_o   (fine_f)
  );

  sym_seg_dec #(.W(COARSE_W)) u_coarse (.val_i(coarse_f), .dir_i(upper_d), .therm_o(coarse_d));
  sym_seg_dec #(.W(MID_W))    u_mid    (.val_i(mid_f),    .dir_i(upper_d), .therm_o(mid_d));
  sym_seg_dec #(.W(FINE_W))   u_fine   (.val_i(fine_f),   .dir_i(upper_d), .therm_o(fine_d));

  bank_route u_route (.upper_i(upper_d), .route_o(route_d));

  // single decode-and-hold stage; all segments share one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_o <= '0;
      mid_o    <= '0;
      fine_o   <= '0;
      upper_o  <= 1'b0;
      route_q  <= ROUTE_LOWER;
    end else begin
      coarse_o <= coarse_d;
      mid_o    <= mid_d;
      fine_o   <= fine_d;
      upper_o  <= upper_d;
      route_q  <= route_d;
    end
  end

  assign p_to_true_o = route_q.p_true;
  assign n_to_true_o = route_q.n_true;
  assign p_to_inv_o  = route_q.p_inv;
  assign n_to_inv_o  = route_q.n_inv;

  // R6
  therm_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((coarse_o + CL'(1)) & coarse_o) == '0) &&
    (((mid_o + ML'(1)) & mid_o) == '0) &&
    (((fine_o + FL'(1)) & fine_o) == '0));

  // R7
  weighted_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ($countones(coarse_o) * (1 << (MID_W + FINE_W)) +
                $countones(mid_o) * (1 << FINE_W) + $countones(fine_o)) ==
               ($past(code_i[CODE_W-1]) ? SEG_MAX - int'($past(code_i[SEG_W-1:0]))
                                        : int'($past(code_i[SEG_W-1:0]))));

  // R9
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({p_to_true_o, n_to_true_o}) == 1) &&
    ($countones({p_to_inv_o, n_to_inv_o}) == 1) &&
    (n_to_true_o == upper_o) && (p_to_inv_o == upper_o));

  // R2
  half_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> upper_o == $past(code_i[CODE_W-1]));
endmodule

// File: tb/sym_therm_dec_test.sv
`timescale 1ns/1ps
module sym_therm_dec_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] code_i = '0;
  logic [6:0]  coarse_o, mid_o;
  logic [30:0] fine_o;
  logic        upper_o, p_to_true_o, n_to_true_o, p_to_inv_o, n_to_inv_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sym_therm_dec uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] therm(input int n);
    return 31'((32'd1 << n) - 1);
  endfunction

  function automatic logic [44:0] lines();
    return {coarse_o, mid_o, fine_o};
  endfunction

  function automatic logic [44:0] exp_lines(input logic [11:0] c);
    logic [10:0] m;
    m = c[11] ? 11'd2047 - c[10:0] : c[10:0];
    return {therm(int'(m[10:8]))[6:0], therm(int'(m[7:5]))[6:0], therm(int'(m[4:0]))};
  endfunction

  // drive at negedge, sample 1 ns after the loading edge
  task automatic apply(input logic [11:0] c);
    @(negedge clk_i) code_i = c;
    @(posedge clk_i) #1;
  endtask

  task automatic t_reset();
    code_i = 12'hABC;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check({lines(), upper_o, p_to_true_o, n_to_true_o, p_to_inv_o, n_to_inv_o} == {45'd0, 5'b01001},
          "R1 reset state", {lines(), upper_o, p_to_true_o, n_to_true_o, p_to_inv_o, n_to_inv_o},
          {45'd0, 5'b01001});
    rst_ni = 1'b1;
  endtask

  task automatic t_async_reset();
    apply(12'hFFE);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check(lines() == 45'd0 && upper_o == 1'b0 && p_to_true_o && n_to_inv_o, "R1 async reset",
          {lines(), upper_o}, {45'd0, 1'b0});
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic t_latency();
    apply(12'h000);
    @(negedge clk_i) code_i = 12'h7FF;
    #9;
    check(lines() == 45'd0, "R2 holds before edge", lines(), 45'd0);
    #2;
    check(lines() == {45{1'b1}}, "R2 all segments same edge", lines(), {45{1'b1}});
    @(negedge clk_i) code_i = 12'hFFF;
    #9;
    check(upper_o == 1'b0, "R2 half holds before edge", upper_o, 1'b0);
    #2;
    check(upper_o == 1'b1 && lines() == 45'd0, "R2 half and lines same edge", {lines(), upper_o}, {45'd0, 1'b1});
  endtask

  task automatic t_fields();
    apply(12'b0_101_000_00000);
    check(lines() == {7'h1F, 7'h00, 31'h0}, "R3 coarse field", lines(), {7'h1F, 7'h00, 31'h0});
    apply(12'b0_000_011_00000);
    check(lines() == {7'h00, 7'h07, 31'h0}, "R3 middle field", lines(), {7'h00, 7'h07, 31'h0});
    apply(12'b0_000_000_10011);
    check(lines() == {7'h00, 7'h00, 31'h7FFFF}, "R3 fine field", lines(), {7'h00, 7'h00, 31'h7FFFF});
    apply(12'b1_110_000_11111);
    check(lines() == {7'h01, 7'h7F, 31'h0}, "R5 mirrored fields", lines(), {7'h01, 7'h7F, 31'h0});
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 4096; c++) begin
      logic [11:0] cv;
      int sum, sexp;
      cv = 12'(c);
      apply(cv);
      check(lines() == exp_lines(cv), cv[11] ? "R5 R6 sweep upper" : "R4 R6 sweep lower", lines(), exp_lines(cv));
      sum  = $countones(coarse_o) * 256 + $countones(mid_o) * 32 + $countones(fine_o);
      sexp = cv[11] ? 2047 - int'(cv[10:0]) : int'(cv[10:0]);
      check(sum == sexp, "R7 weighted sum", 64'(sum), 64'(sexp));
      check({upper_o, p_to_true_o, n_to_true_o, p_to_inv_o, n_to_inv_o} ==
            (cv[11] ? 5'b10110 : 5'b01001), "R9 routing",
            {upper_o, p_to_true_o, n_to_true_o, p_to_inv_o, n_to_inv_o}, cv[11] ? 5'b10110 : 5'b01001);
    end
  endtask

  task automatic t_symmetry();
    for (int c = 0; c < 2048; c++) begin
      logic [44:0] lo_lines;
      logic        lo_half;
      apply(12'(c));
      lo_lines = lines();
      lo_half  = upper_o;
      apply(12'(4095 - c));
      check(lines() == lo_lines && upper_o != lo_half, "R8 mirror pair", {lines(), upper_o}, {lo_lines, ~lo_half});
    end
    apply(12'd2047);
    check(lines() == {45{1'b1}}, "R8 seam below", lines(), {45{1'b1}});
    apply(12'd2048);
    check(lines() == {45{1'b1}} && upper_o, "R8 seam above", {lines(), upper_o}, {{45{1'b1}}, 1'b1});
  endtask

  initial begin
    t_reset();
    t_latency();
    t_fields();
    t_sweep();
    t_symmetry();
    t_async_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule